// File: doc/BRIEF.md
# Two-Level Page Table Walker

After a translation buffer misses, this block finds the translation for a 32-bit virtual address. It reads two page-table entries from physical memory. Table reads use physical addresses and are never translated. The first-level table starts at a root address that the caller supplies with the request. The upper ten address bits select an entry in that table. The middle ten bits select an entry in the second-level table, whose page the first entry names. The low twelve bits are the page offset, which the walker does not use.

The block handles one walk at a time. Each entry read goes out through a small request/response memory port. A request is held until the memory accepts it, and a response may come back any number of cycles later. The walk stops at the first entry that marks its page absent. In that case the walker reports a page fault for the original access. Otherwise it returns the leaf entry's physical page number and its permission bits. The result appears as a one-cycle completion pulse.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. At that edge `req_vaddr` and `root_base` are captured. `req_ready` stays 0 from the cycle after acceptance up to and including the completion pulse, and `req_ready` returns to 1 the cycle after the pulse. Changes on `req_valid`, `req_vaddr` and `root_base` while busy have no effect on the walk.
- R3: In the cycle after acceptance, `mem_req_addr` is `root + 4*va[31:22]` (first-level entry, 4-byte entries) and `mem_req_valid` is 1.
- R4: A memory request stays asserted with an unchanged address until a cycle in which `mem_req_ready` is 1.
- R5: After a present first-level entry returns, the next request reads `{entry[31:12], 12'h000} + 4*va[21:12]`.
- R6: Each entry is 32 bits. Bit 0 is present, bit 1 is read permission, bit 2 is write permission, bit 3 is dirty, and bits 31:12 are the physical page number. Bits 11:4 are ignored.
- R7: If the first-level entry has bit 0 clear, no second read is issued. In the cycle after that response, the walker pulses `done_valid` with `done_fault`=1 and with `done_ppn`, `done_rd`, `done_wr` and `done_dirty` all 0.
- R8: If the second-level entry has bit 0 clear, the walker reports the same fault pulse with all result fields 0.
- R9: If both entries are present, `done_valid` pulses in the cycle after the second response. The pulse carries `done_fault`=0, `done_ppn` = leaf bits 31:12, and `done_rd`/`done_wr`/`done_dirty` = leaf bits 1/2/3.
- R10: Only one memory read is outstanding at a time. `mem_req_valid` is 0 from the acceptance of a read until its response arrives.
- R11: `done_valid` is high for exactly one cycle per accepted request and is otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical address of the first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended on an absent entry |
| done_ppn | output | 20 | Physical page number of the leaf |
| done_rd | output | 1 | Leaf read permission |
| done_wr | output | 1 | Leaf write permission |
| done_dirty | output | 1 | Leaf dirty flag |

## Verification
Walks run with zero-latency memory and with stalled, slow memory. Comparing the two separates the request-hold behaviour from response timing. Virtual addresses with both indices at zero and at their maximum test the index scaling at both edges of each table. Two kinds of absent entry are tried. An absent first-level entry must suppress the second read, and an absent leaf must still produce the fault. One walk changes the request inputs while busy, which shows that the captured root and address are the ones used.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int OFF_W      = 12;
    localparam int IDX_W      = 10;
    localparam int PTE_BYTES  = 4;
    localparam int PTE_W      = PTE_BYTES * 8;
    localparam int PPN_W      = PA_W - OFF_W;
    localparam int ESZ_SH     = $clog2(PTE_BYTES);
    localparam int HI_IDX_LSB = OFF_W + IDX_W;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_RD      = 1;
    localparam int BIT_WR      = 2;
    localparam int BIT_DIRTY   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WT1,
        ST_RD2,
        ST_WT2,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        logic             present;
        logic             rd;
        logic             wr;
        logic             dirty;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        logic [PA_W-1:0]  root;
        logic [PPN_W-1:0] tbl_ppn;
        pte_t             leaf;
    } walk_regs_t;
endpackage

// File: rtl/pgwalk_pte_unpack.sv
module pgwalk_pte_unpack
    import pgwalk_pkg::*;
(
    input  logic [PTE_W-1:0] raw_i,
    output pte_t             pte_o
);
    logic unused_rsvd;

    always_comb begin
        pte_o.present = raw_i[BIT_PRESENT];
        pte_o.rd      = raw_i[BIT_RD];
        pte_o.wr      = raw_i[BIT_WR];
        pte_o.dirty   = raw_i[BIT_DIRTY];
        pte_o.ppn     = raw_i[PTE_W-1 -: PPN_W];
    end

    assign unused_rsvd = ^raw_i[PTE_W-PPN_W-1:BIT_DIRTY+1];
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
    import pgwalk_pkg::*;
(
    input  logic [PA_W-1:0]  root_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [PPN_W-1:0] tbl_ppn_i,
    input  logic             level2_i,
    output logic [PA_W-1:0]  addr_o
);
    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] idx_lo;
    logic [PA_W-1:0]  base;
    logic [PA_W-1:0]  scaled;

    assign idx_hi = va_i[HI_IDX_LSB +: IDX_W];
    assign idx_lo = va_i[OFF_W +: IDX_W];

    always_comb begin
        base   = level2_i ? {tbl_ppn_i, {OFF_W{1'b0}}} : root_i;
        scaled = '0;
        scaled[ESZ_SH +: IDX_W] = level2_i ? idx_lo : idx_hi;
        addr_o = base + scaled;
    end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [PA_W-1:0]  root_base_i,
    output logic             req_ready_o,
    input  logic             mem_req_ready_i,
    input  logic             mem_rsp_valid_i,
    input  pte_t             pte_i,
    output logic             mem_req_valid_o,
    output logic             level2_o,
    output logic [VA_W-1:0]  va_o,
    output logic [PA_W-1:0]  root_o,
    output logic [PPN_W-1:0] tbl_ppn_o,
    output logic             done_valid_o,
    output logic             done_fault_o,
    output logic [PPN_W-1:0] done_ppn_o,
    output logic             done_rd_o,
    output logic             done_wr_o,
    output logic             done_dirty_o
);
    walk_regs_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    walk_d.st      = ST_RD1;
                    walk_d.va      = req_vaddr_i;
                    walk_d.root    = root_base_i;
                    walk_d.tbl_ppn = '0;
                    walk_d.leaf    = '0;
                end
            end
            ST_RD1: begin
                if (mem_req_ready_i) walk_d.st = ST_WT1;
            end
            ST_WT1: begin
                if (mem_rsp_valid_i) begin
                    if (pte_i.present) begin
                        walk_d.tbl_ppn = pte_i.ppn;
                        walk_d.st      = ST_RD2;
                    end else begin
                        walk_d.st = ST_FAULT;
                    end
                end
            end
            ST_RD2: begin
                if (mem_req_ready_i) walk_d.st = ST_WT2;
            end
            ST_WT2: begin
                if (mem_rsp_valid_i) begin
                    if (pte_i.present) begin
                        walk_d.leaf = pte_i;
                        walk_d.st   = ST_DONE;
                    end else begin
                        walk_d.st = ST_FAULT;
                    end
                end
            end
            ST_DONE, ST_FAULT: walk_d.st = ST_IDLE;
            default:           walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    logic hit_ok;
    assign hit_ok          = (walk_q.st == ST_DONE);
    assign req_ready_o     = (walk_q.st == ST_IDLE);
    assign mem_req_valid_o = (walk_q.st == ST_RD1) || (walk_q.st == ST_RD2);
    assign level2_o        = (walk_q.st == ST_RD2);
    assign va_o            = walk_q.va;
    assign root_o          = walk_q.root;
    assign tbl_ppn_o       = walk_q.tbl_ppn;
    assign done_valid_o    = hit_ok || (walk_q.st == ST_FAULT);
    assign done_fault_o    = (walk_q.st == ST_FAULT);
    assign done_ppn_o      = hit_ok ? walk_q.leaf.ppn   : '0;
    assign done_rd_o       = hit_ok ? walk_q.leaf.rd    : 1'b0;
    assign done_wr_o       = hit_ok ? walk_q.leaf.wr    : 1'b0;
    assign done_dirty_o    = hit_ok ? walk_q.leaf.dirty : 1'b0;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |=> !done_valid_o); // R11
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (!req_ready_o && mem_req_valid_o)); // R2
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o); // R10
    AST_FAULT_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_o && done_fault_o) |-> (done_ppn_o == '0 && !done_rd_o && !done_wr_o && !done_dirty_o)); // R7
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic             done_fault,
    output logic [PPN_W-1:0] done_ppn,
    output logic             done_rd,
    output logic             done_wr,
    output logic             done_dirty
);
    pte_t             rsp_pte;
    logic             level2;
    logic [VA_W-1:0]  va_held;
    logic [PA_W-1:0]  root_held;
    logic [PPN_W-1:0] tbl_ppn;

    pgwalk_pte_unpack u_unpack (
        .raw_i (mem_rsp_data),
        .pte_o (rsp_pte)
    );

    pgwalk_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_vaddr_i     (req_vaddr),
        .root_base_i     (root_base),
        .req_ready_o     (req_ready),
        .mem_req_ready_i (mem_req_ready),
        .mem_rsp_valid_i (mem_rsp_valid),
        .pte_i           (rsp_pte),
        .mem_req_valid_o (mem_req_valid),
        .level2_o        (level2),
        .va_o            (va_held),
        .root_o          (root_held),
        .tbl_ppn_o       (tbl_ppn),
        .done_valid_o    (done_valid),
        .done_fault_o    (done_fault),
        .done_ppn_o      (done_ppn),
        .done_rd_o       (done_rd),
        .done_wr_o       (done_wr),
        .done_dirty_o    (done_dirty)
    );

    pgwalk_addr_gen u_addr (
        .root_i    (root_held),
        .va_i      (va_held),
        .tbl_ppn_i (tbl_ppn),
        .level2_i  (level2),
        .addr_o    (mem_req_addr)
    );

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done_valid)); // R1
endmodule

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic        done_fault;
    logic [19:0] done_ppn;
    logic        done_rd;
    logic        done_wr;
    logic        done_dirty;

    always #2.5 clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault),
        .done_ppn(done_ppn), .done_rd(done_rd), .done_wr(done_wr),
        .done_dirty(done_dirty)
    );

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    logic m_idle = 1'b1;
    logic m_done = 1'b0;
    logic [31:0] pmem [logic [31:0]];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model comparison every clock: busy/idle and completion pulse
    task automatic tick();
        @(negedge clk);
        chk("R2 req_ready per cycle", {63'b0, req_ready}, {63'b0, m_idle});
        chk("R11 done_valid per cycle", {63'b0, done_valid}, {63'b0, m_done});
    endtask

    task automatic mem_phase(input logic [31:0] exp_addr, input int stall, input int lat,
                             input logic [31:0] data, input bit last, input string tag);
        chk({tag, " request raised"}, {63'b0, mem_req_valid}, 64'd1);
        chk({tag, " entry address"}, {32'b0, mem_req_addr}, {32'b0, exp_addr});
        mem_req_ready = 1'b0;
        for (int i = 0; i < stall; i++) begin
            tick();
            chk("R4 request held", {63'b0, mem_req_valid}, 64'd1);
            chk("R4 address stable", {32'b0, mem_req_addr}, {32'b0, exp_addr});
        end
        mem_req_ready = 1'b1;
        tick();
        mem_req_ready = 1'b0;
        chk("R10 no request while waiting", {63'b0, mem_req_valid}, 64'd0);
        for (int i = 0; i < lat; i++) begin
            tick();
            chk("R10 no request while waiting", {63'b0, mem_req_valid}, 64'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        if (last) m_done = 1'b1;
        tick();
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] root,
                        input int s1, input int l1, input int s2, input int l2, input bit noise);
        logic [31:0] a1, a2, p1, p2;
        bit          f;
        string       tg;
        a1 = root + {20'b0, va[31:22], 2'b00};
        p1 = rd(a1);
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = root;
        m_idle = 1'b0;
        tick();
        if (noise) begin
            req_vaddr = ~va;
            root_base = root ^ 32'h0001_F000;
        end else begin
            req_valid = 1'b0;
        end
        mem_phase(a1, s1, l1, p1, !p1[0], "R3");
        if (p1[0]) begin
            a2 = {p1[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
            p2 = rd(a2);
            mem_phase(a2, s2, l2, p2, 1'b1, "R5");
            f  = !p2[0];
            tg = f ? "R8" : "R9";
        end else begin
            chk("R7 no second read", {63'b0, mem_req_valid}, 64'd0);
            f  = 1'b1;
            tg = "R7";
            p2 = '0;
        end
        m_done    = 1'b0;
        req_valid = 1'b0;
        chk({tg, " fault flag"}, {63'b0, done_fault}, {63'b0, f});
        if (f) begin
            chk({tg, " ppn zero"}, {44'b0, done_ppn}, 64'd0);
            chk({tg, " perms zero"}, {61'b0, done_rd, done_wr, done_dirty}, 64'd0);
        end else begin
            chk("R9 R6 ppn", {44'b0, done_ppn}, {44'b0, p2[31:12]});
            chk("R9 R6 read bit", {63'b0, done_rd}, {63'b0, p2[1]});
            chk("R9 R6 write bit", {63'b0, done_wr}, {63'b0, p2[2]});
            chk("R9 R6 dirty bit", {63'b0, done_dirty}, {63'b0, p2[3]});
        end
        m_idle = 1'b1;
        tick();
        chk("R2 idle after walk, no request", {63'b0, mem_req_valid}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // tables: root 0x0001_0000
        pmem[32'h0001_0004] = 32'h0002_0001;  // L1 idx 1 -> table at 0x20000
        pmem[32'h0001_0000] = 32'h0002_0001;  // L1 idx 0 -> same table
        pmem[32'h0001_0FFC] = 32'h0003_0001;  // L1 idx 1023 -> table at 0x30000
        pmem[32'h0001_0008] = 32'h0004_0FF0;  // L1 idx 2 absent, other bits set
        pmem[32'h0002_000C] = 32'h000A_B00F;  // leaf: ppn AB, p r w d
        pmem[32'h0002_0014] = 32'h0005_000E;  // leaf absent
        pmem[32'h0002_0000] = 32'h0000_1FF5;  // leaf: ppn 1, p w, junk 11:4
        pmem[32'h0003_0FFC] = 32'hFFFF_F003;  // leaf: ppn FFFFF, p r

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 reset req_ready", {63'b0, req_ready}, 64'd1);
        chk("R1 reset mem_req_valid", {63'b0, mem_req_valid}, 64'd0);
        chk("R1 reset done_valid", {63'b0, done_valid}, 64'd0);
        tick();

        walk(32'h0040_3ABC, 32'h0001_0000, 0, 0, 0, 0, 1'b0);  // fast memory
        walk(32'h0040_3ABC, 32'h0001_0000, 3, 4, 2, 5, 1'b0);  // stalls and latency
        walk(32'hFFFF_F123, 32'h0001_0000, 1, 0, 0, 2, 1'b1);  // max indices, busy noise
        walk(32'h0000_0FFF, 32'h0001_0000, 0, 1, 1, 0, 1'b0);  // zero indices, reserved bits
        walk(32'h0080_0000, 32'h0001_0000, 2, 1, 0, 0, 1'b0);  // L1 absent
        walk(32'h0040_5000, 32'h0001_0000, 0, 0, 3, 1, 1'b1);  // L2 absent
        walk(32'h0040_3ABC, 32'h0005_0000, 0, 2, 0, 0, 1'b0);  // other root, empty
        walk(32'h0040_3ABC, 32'h0001_0000, 0, 0, 0, 0, 1'b0);  // back to back

        repeat (2) tick();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule